// File: doc/BRIEF.md
# Descriptor ROM Header Validator

This block checks the fixed header at the front of a device descriptor image. The image arrives one byte per accepted cycle, starting at offset 0. The block keeps a count of accepted bytes. It captures the identity and size fields at their offsets, and it runs two checksums over two fixed windows of the same stream. When the image ends, the block latches a verdict and holds it, together with the captured fields, until the next `start`.

A source asserts `start` once for each image. It then presents bytes with `byte_valid`, and it marks the final byte it can supply with `byte_last`. The block works out the expected image length from the length field. It stops by itself once that many bytes have been accepted, or once it can tell that the header is too small. Only a failed ID checksum, a header that is too small or a stream that ends early make the image fatal. A data checksum mismatch and an unknown revision are reported as warnings.

Top module: `drom_hdr_check`

## Requirements
- R1: Reset and `start` both clear the block: `done`, `pass`, every flag and every captured field read 0. A byte presented in the same cycle as `start` is discarded.
- R2: Fields are captured little-endian. `uid` is built from bytes 1..8 (byte 1 is the least significant). `vendor_id` comes from bytes 16..17 and `model_id` from bytes 18..19. `data_len` is the 10-bit value {byte15[1:0], byte14}, and bits 7..2 of byte 15 have no effect on it.
- R3: Byte 0 is compared with a CRC-8 over bytes 1..8. The CRC-8 uses polynomial 0x07 and initial value 0xFF, processes each byte MSB first and has no final inversion. A mismatch raises `id_bad`, which is fatal. `id_bad` stays 0 if fewer than 9 bytes arrived.
- R4: Bytes 9..12 hold a little-endian 32-bit value. It is compared with a reflected CRC-32C (polynomial 0x82F63B78, initial value all-ones, final inversion) over bytes 13..size-1. A mismatch on a complete image raises `data_warn` only, and `pass` is not affected.
- R5: The image size is data_len + 13. If that is below 22, `size_bad` and `done` rise in the cycle after byte 15 is accepted.
- R6: For a size of 22 or more, `done` rises in the cycle after byte size-1 is accepted. `done`, the flags and the fields then hold until `start`.
- R7: If `byte_last` arrives with a byte before the expected end (and not as byte 15 of a too-small header), `trunc` and `done` rise in the following cycle.
- R8: `rev_warn` is raised when byte 13 was received and is greater than 2.
- R9: Bytes presented while `done` is high are ignored, and the captured fields do not change.
- R10: `pass` equals `done` with none of `id_bad`, `size_bad` or `trunc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the block for a new image |
| byte_valid | input | 1 | `byte_data` carries the next image byte |
| byte_data | input | 8 | Image byte |
| byte_last | input | 1 | This byte is the last one the source can supply |
| done | output | 1 | Verdict and fields are valid |
| pass | output | 1 | Image accepted |
| id_bad | output | 1 | ID checksum mismatch (fatal) |
| size_bad | output | 1 | Declared size below the header length (fatal) |
| trunc | output | 1 | Stream ended early (fatal) |
| data_warn | output | 1 | Data CRC-32C mismatch (warning) |
| rev_warn | output | 1 | Revision above 2 (warning) |
| uid | output | 64 | Unique ID |
| vendor_id | output | 16 | Vendor ID |
| model_id | output | 16 | Model ID |
| data_len | output | 10 | Data length field |

## Verification
Every verdict flag and `done` becomes visible exactly one cycle after the edge that accepts the terminating byte. That byte is byte 15 for a too-small header, byte size-1 for a complete image, or the byte flagged last. The bench drives each byte on a falling edge. On the next falling edge it compares `done` with what its queue-based model predicts for that byte, so an early or late verdict shows up in the very cycle it happens. Idle cycles between bytes are checked to keep `done` low. The fields and flags are compared once the verdict is due, and again after extra bytes have been sent into a finished image.

// File: rtl/drom_hdr_check.sv
module drom_hdr_check #(
  parameter int LEN_W     = 10,
  parameter int DATA_OFS  = 13,
  parameter int HDR_LEN   = 22,
  parameter int REV_MAX   = 2,
  parameter logic [7:0]  CRC8_POLY  = 8'h07,
  parameter logic [31:0] CRC32_POLY = 32'h82F63B78
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        byte_last,
  output logic        done,
  output logic        pass,
  output logic        id_bad,
  output logic        size_bad,
  output logic        trunc,
  output logic        data_warn,
  output logic        rev_warn,
  output logic [63:0] uid,
  output logic [15:0] vendor_id,
  output logic [15:0] model_id,
  output logic [LEN_W-1:0] data_len
);
  localparam int CNT_W = LEN_W + 2;
  localparam logic [CNT_W-1:0] I_UID  = CNT_W'(1);
  localparam logic [CNT_W-1:0] I_DCRC = CNT_W'(9);
  localparam logic [CNT_W-1:0] I_REV  = CNT_W'(DATA_OFS);
  localparam logic [CNT_W-1:0] I_LENL = CNT_W'(14);
  localparam logic [CNT_W-1:0] I_LENH = CNT_W'(15);
  localparam logic [CNT_W-1:0] I_VID  = CNT_W'(16);
  localparam logic [CNT_W-1:0] I_MID  = CNT_W'(18);
  localparam logic [CNT_W-1:0] I_END  = CNT_W'(20);
  localparam logic [CNT_W-1:0] OFS    = CNT_W'(DATA_OFS);
  localparam logic [CNT_W-1:0] HDR_SZ = CNT_W'(HDR_LEN);
  localparam logic [7:0]       REV_LIM = 8'(REV_MAX);

  function automatic logic [7:0] crc8_step(logic [7:0] c, logic [7:0] d);
    logic [7:0] v;
    v = c ^ d;
    for (int k = 0; k < 8; k++) v = {v[6:0], 1'b0} ^ (v[7] ? CRC8_POLY : 8'h00);
    return v;
  endfunction

  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] v;
    v = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) v = {1'b0, v[31:1]} ^ (v[0] ? CRC32_POLY : 32'h0);
    return v;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [7:0]  chk, rev, len_lo, crc8;
  logic [31:0] dref, crc32;

  wire              take    = byte_valid & ~done & ~start;
  wire [LEN_W-1:0]  len_now = LEN_W'({byte_data, len_lo});
  wire [CNT_W-1:0]  size_now = CNT_W'(len_now) + OFS;
  wire [CNT_W-1:0]  end_idx  = CNT_W'(data_len) + OFS - CNT_W'(1);
  wire [2:0]        uid_sel  = 3'(cnt - I_UID);
  wire [1:0]        dref_sel = 2'(cnt - I_DCRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; done <= 1'b0; size_bad <= 1'b0; trunc <= 1'b0;
      chk <= '0; rev <= '0; len_lo <= '0; dref <= '0;
      uid <= '0; vendor_id <= '0; model_id <= '0; data_len <= '0;
      crc8 <= 8'hFF; crc32 <= '1;
    end else if (start) begin
      cnt <= '0; done <= 1'b0; size_bad <= 1'b0; trunc <= 1'b0;
      chk <= '0; rev <= '0; len_lo <= '0; dref <= '0;
      uid <= '0; vendor_id <= '0; model_id <= '0; data_len <= '0;
      crc8 <= 8'hFF; crc32 <= '1;
    end else if (take) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == '0) chk <= byte_data;
      if (cnt >= I_UID && cnt < I_DCRC) begin
        uid[{uid_sel, 3'b000} +: 8] <= byte_data;
        crc8 <= crc8_step(crc8, byte_data);
      end
      if (cnt >= I_DCRC && cnt < I_REV) dref[{dref_sel, 3'b000} +: 8] <= byte_data;
      if (cnt == I_REV)  rev <= byte_data;
      if (cnt == I_LENL) len_lo <= byte_data;
      if (cnt == I_LENH) data_len <= len_now;
      if (cnt >= I_VID && cnt < I_MID) vendor_id[{cnt[0], 3'b000} +: 8] <= byte_data;
      if (cnt >= I_MID && cnt < I_END) model_id[{cnt[0], 3'b000} +: 8] <= byte_data;
      if (cnt >= OFS) crc32 <= crc32_step(crc32, byte_data);
      if (cnt == I_LENH && size_now < HDR_SZ) begin
        done <= 1'b1; size_bad <= 1'b1;
      end else if (cnt > I_LENH && cnt == end_idx) begin
        done <= 1'b1;
      end else if (byte_last) begin
        done <= 1'b1; trunc <= 1'b1;
      end
    end
  end

  assign id_bad    = done & (cnt > I_DCRC - CNT_W'(1)) & (crc8 != chk);
  assign data_warn = done & ~trunc & ~size_bad & (~crc32 != dref);
  assign rev_warn  = done & (cnt > I_REV) & (rev > REV_LIM);
  assign pass      = done & ~id_bad & ~size_bad & ~trunc;
endmodule

module drom_hdr_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic        pass,
  input logic        id_bad,
  input logic        size_bad,
  input logic        trunc,
  input logic [63:0] uid,
  input logic [9:0]  data_len
);
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !size_bad && !trunc);
  p_id_bad_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    id_bad |-> done);
  p_size_bad_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    size_bad |-> done && !trunc);
  p_verdict_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(size_bad) && $stable(trunc));
  p_trunc_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trunc |-> done);
  p_fields_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(uid) && $stable(data_len));
  p_fatal_blocks_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_bad || size_bad || trunc) |-> !pass);
  p_pass_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
endmodule

bind drom_hdr_check drom_hdr_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
  .id_bad(id_bad), .size_bad(size_bad), .trunc(trunc), .uid(uid),
  .data_len(data_len)
);

// File: tb/drom_hdr_check_test.sv
module drom_hdr_check_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, vld = 1'b0, last = 1'b0;
  logic [7:0] din = '0;
  logic done, pass, id_bad, size_bad, trunc, data_warn, rev_warn;
  logic [63:0] uid;
  logic [15:0] vendor_id, model_id;
  logic [9:0] data_len;
  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] img[$];

  always #5 clk = ~clk;

  drom_hdr_check uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(vld), .byte_data(din),
    .byte_last(last), .done(done), .pass(pass), .id_bad(id_bad), .size_bad(size_bad),
    .trunc(trunc), .data_warn(data_warn), .rev_warn(rev_warn), .uid(uid),
    .vendor_id(vendor_id), .model_id(model_id), .data_len(data_len)
  );

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc8(input int a, input int b);
    logic [7:0] v = 8'hFF;
    for (int i = a; i <= b; i++) begin
      v ^= img[i];
      for (int k = 0; k < 8; k++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    end
    return v;
  endfunction

  function automatic logic [31:0] ref_crc32c(input int a, input int b);
    logic [31:0] v = 32'hFFFFFFFF;
    for (int i = a; i <= b; i++) begin
      v ^= 32'(img[i]);
      for (int k = 0; k < 8; k++) v = v[0] ? ((v >> 1) ^ 32'h82F63B78) : (v >> 1);
    end
    return ~v;
  endfunction

  task automatic build(input int dlen, input logic [7:0] rev, input logic [63:0] u,
                       input logic [15:0] vid, input logic [15:0] mid,
                       input bit bad_id, input bit bad_data, input logic [5:0] hi);
    int size = dlen + 13;
    int n = (size > 22) ? size : 22;
    logic [31:0] c;
    img.delete();
    for (int i = 0; i < n; i++) img.push_back(8'((i * 37 + 5) & 255));
    for (int k = 0; k < 8; k++) img[1 + k] = u[8 * k +: 8];
    img[13] = rev;
    img[14] = dlen[7:0];
    img[15] = {hi, 2'(dlen >> 8)};
    img[16] = vid[7:0]; img[17] = vid[15:8];
    img[18] = mid[7:0]; img[19] = mid[15:8];
    img[0] = ref_crc8(1, 8) ^ (bad_id ? 8'h5A : 8'h00);
    c = (size >= 22) ? ref_crc32c(13, size - 1) : 32'h0;
    if (bad_data) c ^= 32'h0000_0100;
    for (int k = 0; k < 4; k++) img[9 + k] = c[8 * k +: 8];
  endtask

  task automatic pulse_start(input bit with_byte);
    @(negedge clk);
    start = 1'b1;
    vld = with_byte; din = 8'hC3;
    @(negedge clk);
    start = 1'b0; vld = 1'b0;
    cmp("R1 done after start", 64'(done), 64'd0);
    cmp("R1 flags after start", {size_bad, trunc, id_bad, pass}, 64'd0);
    cmp("R1 uid after start", uid, 64'd0);
  endtask

  task automatic run(input int nsend, input int gap);
    int dlen = {img[15][1:0], img[14]};
    int size = dlen + 13;
    int n = 0;
    bit compl = 1'b0, sbad = 1'b0, e_id, e_rev, e_dw, e_tr;
    logic [31:0] stored;
    for (int i = 0; i < nsend; i++) begin
      bit exp_d;
      vld = 1'b1; din = img[i]; last = (i == nsend - 1);
      @(negedge clk);
      vld = 1'b0; last = 1'b0;
      n = i + 1;
      sbad  = (i == 15) && (size < 22);
      compl = (i > 15) && (size >= 22) && (i == size - 1);
      exp_d = sbad || compl || (i == nsend - 1);
      cmp("R6 done timing per byte", 64'(done), 64'(exp_d));
      if (exp_d) break;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        cmp("R6 done low during idle", 64'(done), 64'd0);
      end
    end
    e_tr = !compl && !sbad;
    e_id = (n >= 9) && (ref_crc8(1, 8) != img[0]);
    e_rev = (n >= 14) && (img[13] > 8'd2);
    stored = {img[12], img[11], img[10], img[9]};
    e_dw = compl && (ref_crc32c(13, size - 1) != stored);
    cmp("R5 size_bad", 64'(size_bad), 64'(sbad));
    cmp("R7 trunc", 64'(trunc), 64'(e_tr));
    cmp("R3 id_bad", 64'(id_bad), 64'(e_id));
    cmp("R8 rev_warn", 64'(rev_warn), 64'(e_rev));
    cmp("R4 data_warn", 64'(data_warn), 64'(e_dw));
    cmp("R10 pass", 64'(pass), 64'(!(e_id || sbad || e_tr)));
    if (compl) begin
      logic [63:0] u = '0;
      for (int k = 0; k < 8; k++) u[8 * k +: 8] = img[1 + k];
      cmp("R2 uid", uid, u);
      cmp("R2 vendor_id", 64'(vendor_id), 64'({img[17], img[16]}));
      cmp("R2 model_id", 64'(model_id), 64'({img[19], img[18]}));
      cmp("R2 data_len", 64'(data_len), 64'(dlen));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 done at reset", 64'(done), 64'd0);
    cmp("R1 pass at reset", 64'(pass), 64'd0);
    cmp("R1 uid at reset", uid, 64'd0);
    rst_n = 1'b1;

    // R6 minimal complete image, good checksums
    pulse_start(1'b0);
    build(9, 8'd1, 64'h0123_4567_89AB_CDEF, 16'h8086, 16'h1234, 0, 0, 6'h0);
    run(img.size(), 0);

    // R9 bytes after done are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); vld = 1'b1; din = 8'hFF; last = 1'b1;
    end
    @(negedge clk); vld = 1'b0; last = 1'b0;
    cmp("R9 uid unchanged", uid, 64'h0123_4567_89AB_CDEF);
    cmp("R9 vendor unchanged", 64'(vendor_id), 64'h8086);
    cmp("R9 still done", 64'(done), 64'd1);

    // R4 data checksum mismatch is a warning only, with idle gaps
    pulse_start(1'b0);
    build(40, 8'd2, 64'hFEDC_BA98_7654_3210, 16'hA1B2, 16'hC3D4, 0, 1, 6'h0);
    run(img.size(), 2);

    // R3 bad ID checksum
    pulse_start(1'b0);
    build(12, 8'd0, 64'h1111_2222_3333_4444, 16'h0001, 16'h0002, 1, 0, 6'h0);
    run(img.size(), 0);

    // R5 declared size too small
    pulse_start(1'b0);
    build(5, 8'd1, 64'h5555_6666_7777_8888, 16'h0003, 16'h0004, 0, 0, 6'h0);
    run(22, 0);
    cmp("R5 data_len captured", 64'(data_len), 64'd5);

    // R7 truncation after byte 9 and after byte 4
    pulse_start(1'b0);
    build(20, 8'd1, 64'h9999_AAAA_BBBB_CCCC, 16'h0005, 16'h0006, 0, 0, 6'h0);
    run(10, 1);
    pulse_start(1'b0);
    build(20, 8'd1, 64'h9999_AAAA_BBBB_CCCC, 16'h0005, 16'h0006, 1, 0, 6'h0);
    run(5, 0);

    // R8 unknown revision
    pulse_start(1'b0);
    build(16, 8'd3, 64'hDEAD_BEEF_0000_0001, 16'h0007, 16'h0008, 0, 0, 6'h0);
    run(img.size(), 0);

    // R2 upper bits of byte 15 ignored
    pulse_start(1'b0);
    build(30, 8'd1, 64'hCAFE_F00D_1234_0000, 16'h0009, 16'h000A, 0, 0, 6'h3F);
    run(img.size(), 0);

    // R1 byte alongside start is dropped
    pulse_start(1'b1);
    build(9, 8'd1, 64'h0F0E_0D0C_0B0A_0908, 16'h4321, 16'h8765, 0, 0, 6'h0);
    run(img.size(), 0);

    // R6 maximum length
    pulse_start(1'b0);
    build(1023, 8'd2, 64'h7777_0000_7777_0000, 16'hBEEF, 16'hFACE, 0, 0, 6'h0);
    run(img.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule